// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This block computes the next fetch address for a five-stage in-order pipeline whose conditional branches are settled in the decode stage. The decode stage has its own zero detector on the branch source register and its own target adder. The adder sums the address that follows the branch with the sign-extended 16-bit offset. With both in decode, a redirect costs one fetch slot instead of three.

The surrounding pipeline owns the program-counter register and the IF/ID register. Each cycle it presents the address being fetched and the decoded branch kind, register value and offset of the instruction in decode. The block returns the address to fetch next, plus two control outputs. `fetchHold` asks that the current fetch not be written into IF/ID. `squashIfId` asks that IF/ID be loaded with a no-op. A 2-bit policy input selects how the branch hazard is handled:
- stall: fetch is held while a branch resolves;
- predict not taken: the wrong-path instruction is squashed when the branch turns out taken;
- delay slot: the instruction after the branch always executes.

The block records the address following each fetched instruction, so the target is formed from the decode instruction's own position. It also marks the decode slot after a hold or a squash as a bubble, so the slot's branch fields are ignored.

Top module: `dec_branch_resolve`

## Requirements
- R1: In the first cycle after reset is released, the decode slot is treated as empty: `fetchHold`=0, `squashIfId`=0 and `nextPc`=`fetchPc`+4, whatever `brKind` carries.
- R2: Branch kind encoding on `brKind`: 0 = no branch, 1 = taken when `regVal` equals zero, 2 = taken when `regVal` is non-zero, 3 = unconditional jump, always taken.
- R3: The branch target is the decode instruction's fetch address plus 4, plus `brOffset` sign-extended from bit 15 to 32 bits, wrapping modulo 2^32.
- R4: With no live branch in decode, `nextPc` = `fetchPc`+4 and both `fetchHold` and `squashIfId` are 0.
- R5: Policy encodings 0 and 3 select stall. A live branch drives `fetchHold`=1 and `squashIfId`=0 in the same cycle. `nextPc` is the target when taken, and otherwise the decode instruction's address plus 4.
- R6: Policy encoding 1 selects predict not taken, which never holds. A taken live branch drives `squashIfId`=1 and `nextPc`=target. A not-taken one drives `squashIfId`=0 and `nextPc`=`fetchPc`+4.
- R7: Policy encoding 2 selects one delay slot. `fetchHold` and `squashIfId` stay 0, so the instruction being fetched executes. `nextPc` is the target when taken, and `fetchPc`+4 otherwise.
- R8: The decode slot in the cycle after any cycle with `fetchHold` or `squashIfId` asserted is a bubble, and its branch fields have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Hazard policy: 0/3 stall, 1 predict not taken, 2 delay slot |
| fetchPc | input | 32 | Address being fetched this cycle |
| brKind | input | 2 | Branch kind of the decode instruction (R2 encoding) |
| regVal | input | 32 | Branch source register value read in decode |
| brOffset | input | 16 | Signed branch offset of the decode instruction |
| nextPc | output | 32 | Address to fetch in the next cycle |
| fetchHold | output | 1 | Drop the current fetch instead of loading IF/ID |
| squashIfId | output | 1 | Load a no-op into IF/ID in place of the current fetch |

## Verification
The bench targets these corner cases:
- Offsets at both ends of the signed range (0x7FFC and 0x8000). A design that zero-extends the offset or forgets the +4 base sends the fetch to a wrong address.
- Both condition kinds with zero and non-zero registers. A swapped zero test flips the redirect decision.
- Bubbles that still carry a jump encoding: the first slot out of reset and the slot after a hold or squash. A design that obeys these issues spurious redirects and chains holds.
- Policy changes between branches. A design that squashes in delay-slot mode, or holds in predict-not-taken mode, is caught on the very next taken branch.

// File: rtl/dbr_pkg.sv
`timescale 1ns/1ps
package dbr_pkg;

  typedef enum logic [1:0] {
    POL_STALL      = 2'd0,
    POL_PREDICT_NT = 2'd1,
    POL_DELAY_SLOT = 2'd2,
    POL_STALL_ALT  = 2'd3
  } policy_e;

  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_EQZ  = 2'd1,
    BK_NEZ  = 2'd2,
    BK_JUMP = 2'd3
  } brKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic selTarget;   // next fetch comes from the branch adder
    logic selRefetch;  // next fetch is the decode instruction's successor
    logic holdFetch;   // drop current fetch
    logic squash;      // load a no-op into IF/ID
  } pcStrobes_t;

endpackage

// File: rtl/dbr_datapath.sv
`timescale 1ns/1ps
module dbr_datapath
  import dbr_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int REG_W       = 32,
  parameter int OFF_W       = 16,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic [REG_W-1:0]  regVal,
  input  logic [OFF_W-1:0]  brOffset,
  input  pcStrobes_t        strobes,
  output logic              regIsZero,
  output logic [ADDR_W-1:0] nextPc
);

  localparam int EXT_W = ADDR_W - OFF_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  logic [ADDR_W-1:0] seqPc;
  logic [ADDR_W-1:0] decNpc;
  logic [ADDR_W-1:0] offExt;
  logic [ADDR_W-1:0] brTarget;

  // fetch-stage incrementer, reused as the fall-through address
  assign seqPc = fetchPc + STEP;

  // successor address of the instruction now entering decode
  always_ff @(posedge clk) begin
    if (!rstN) decNpc <= '0;
    else       decNpc <= seqPc;
  end

  generate
    if (EXT_W > 0) begin : g_sext
      assign offExt = {{EXT_W{brOffset[OFF_W-1]}}, brOffset};
    end else begin : g_trunc
      assign offExt = brOffset[ADDR_W-1:0];
    end
  endgenerate

  // dedicated decode-stage target adder and zero detector
  assign brTarget  = decNpc + offExt;
  assign regIsZero = (regVal == '0);

  always_comb begin
    if (strobes.selTarget)       nextPc = brTarget;
    else if (strobes.selRefetch) nextPc = decNpc;
    else                         nextPc = seqPc;
  end

endmodule

// File: rtl/dbr_control.sv
`timescale 1ns/1ps
module dbr_control
  import dbr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  policy_e    policy,
  input  brKind_e    kind,
  input  logic       regIsZero,
  output pcStrobes_t strobes
);

  logic killSlot;
  logic liveBr;
  logic taken;

  // decode slot after a hold/squash (or out of reset) is a bubble
  always_ff @(posedge clk) begin
    if (!rstN) killSlot <= 1'b1;
    else       killSlot <= strobes.holdFetch | strobes.squash;
  end

  assign liveBr = !killSlot && (kind != BK_NONE);

  always_comb begin
    unique case (kind)
      BK_EQZ:  taken = regIsZero;
      BK_NEZ:  taken = !regIsZero;
      BK_JUMP: taken = 1'b1;
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    strobes = '0;
    if (liveBr) begin
      unique case (policy)
        POL_PREDICT_NT: begin
          strobes.selTarget = taken;
          strobes.squash    = taken;
        end
        POL_DELAY_SLOT: begin
          strobes.selTarget = taken;
        end
        default: begin
          strobes.holdFetch  = 1'b1;
          strobes.selTarget  = taken;
          strobes.selRefetch = !taken;
        end
      endcase
    end
  end

endmodule

// File: rtl/dec_branch_resolve.sv
`timescale 1ns/1ps
module dec_branch_resolve
  import dbr_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int REG_W       = 32,
  parameter int OFF_W       = 16,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic [1:0]        brKind,
  input  logic [REG_W-1:0]  regVal,
  input  logic [OFF_W-1:0]  brOffset,
  output logic [ADDR_W-1:0] nextPc,
  output logic              fetchHold,
  output logic              squashIfId
);

  pcStrobes_t strobes;
  logic       regIsZero;

  dbr_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .policy    (policy_e'(modeSel)),
    .kind      (brKind_e'(brKind)),
    .regIsZero (regIsZero),
    .strobes   (strobes)
  );

  dbr_datapath #(
    .ADDR_W      (ADDR_W),
    .REG_W       (REG_W),
    .OFF_W       (OFF_W),
    .INSTR_BYTES (INSTR_BYTES)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .fetchPc   (fetchPc),
    .regVal    (regVal),
    .brOffset  (brOffset),
    .strobes   (strobes),
    .regIsZero (regIsZero),
    .nextPc    (nextPc)
  );

  assign fetchHold  = strobes.holdFetch;
  assign squashIfId = strobes.squash;

endmodule

// File: rtl/dec_branch_resolve_chk.sv
`timescale 1ns/1ps
module dec_branch_resolve_chk #(
  parameter int ADDR_W      = 32,
  parameter int INSTR_BYTES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        modeSel,
  input logic [1:0]        brKind,
  input logic [ADDR_W-1:0] fetchPc,
  input logic [ADDR_W-1:0] nextPc,
  input logic              fetchHold,
  input logic              squashIfId
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  logic wasLive;
  always_ff @(posedge clk) begin
    if (!rstN) wasLive <= 1'b0;
    else       wasLive <= 1'b1;
  end

  // R1
  reset_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wasLive |-> (!fetchHold && !squashIfId && nextPc == fetchPc + STEP));

  // R4
  no_branch_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brKind == 2'd0) |-> (nextPc == fetchPc + STEP && !fetchHold && !squashIfId));

  // R5
  hold_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchHold |-> ((modeSel == 2'd0 || modeSel == 2'd3) && !squashIfId));

  // R6
  squash_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    squashIfId |-> (modeSel == 2'd1));

  // R7
  delay_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd2) |-> (!fetchHold && !squashIfId));

  // R8
  killed_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchHold || squashIfId) |=> (!fetchHold && !squashIfId && nextPc == fetchPc + STEP));

endmodule

bind dec_branch_resolve dec_branch_resolve_chk #(
  .ADDR_W      (ADDR_W),
  .INSTR_BYTES (INSTR_BYTES)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .modeSel    (modeSel),
  .brKind     (brKind),
  .fetchPc    (fetchPc),
  .nextPc     (nextPc),
  .fetchHold  (fetchHold),
  .squashIfId (squashIfId)
);

// File: tb/dec_branch_resolve_bench.sv
`timescale 1ns/1ps
module dec_branch_resolve_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeSel = '0;
  logic [31:0] fetchPc = '0;
  logic [1:0]  brKind = '0;
  logic [31:0] regVal = '0;
  logic [15:0] brOffset = '0;
  logic [31:0] nextPc;
  logic        fetchHold;
  logic        squashIfId;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  logic [31:0] pcM   = 32'h0000_1000;
  logic [31:0] npcM  = '0;
  bit          killM = 1'b1;
  bit          firstM = 1'b1;

  always #2.5 clk = ~clk;

  dec_branch_resolve u_dec_branch_resolve (
    .clk        (clk),
    .rstN       (rstN),
    .modeSel    (modeSel),
    .fetchPc    (fetchPc),
    .brKind     (brKind),
    .regVal     (regVal),
    .brOffset   (brOffset),
    .nextPc     (nextPc),
    .fetchHold  (fetchHold),
    .squashIfId (squashIfId)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic bit refTaken(input logic [1:0] k, input logic [31:0] r);
    case (k)
      2'd1:    return r == 32'd0;
      2'd2:    return r != 32'd0;
      2'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // one decode cycle: drive, predict, compare, advance model
  task automatic step(input logic [1:0] m, input logic [1:0] k,
                      input logic [31:0] r, input logic [15:0] o);
    bit live, tk, expH, expS;
    logic [31:0] tgt, expN;
    string ctlTag, pcTag;
    @(negedge clk);
    modeSel = m; brKind = k; regVal = r; brOffset = o; fetchPc = pcM;
    #1;
    live = !killM && (k != 2'd0);
    tk   = refTaken(k, r);
    tgt  = npcM + {{16{o[15]}}, o};
    expN = pcM + 32'd4; expH = 1'b0; expS = 1'b0;
    if (killM) begin
      ctlTag = firstM ? "R1" : "R8";
      pcTag  = ctlTag;
    end else if (!live) begin
      ctlTag = "R4"; pcTag = "R4";
    end else begin
      pcTag = tk ? "R3" : "R2";
      if (m == 2'd1) begin
        ctlTag = "R6"; expS = tk;
        if (tk) expN = tgt;
      end else if (m == 2'd2) begin
        ctlTag = "R7";
        if (tk) expN = tgt;
      end else begin
        ctlTag = "R5"; expH = 1'b1;
        expN = tk ? tgt : npcM;
      end
    end
    chk(nextPc === expN, pcTag, nextPc, expN);
    chk(fetchHold === expH, ctlTag, {31'd0, fetchHold}, {31'd0, expH});
    chk(squashIfId === expS, ctlTag, {31'd0, squashIfId}, {31'd0, expS});
    npcM   = pcM + 32'd4;
    killM  = expH | expS;
    firstM = 1'b0;
    pcM    = expN;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: jump encoding in the empty slot right after reset
    step(2'd1, 2'd3, 32'd0, 16'h0100);
    step(2'd0, 2'd0, 32'd0, 16'd0);
    for (int m = 0; m < 4; m++) begin
      // R3: extreme offsets
      step(m[1:0], 2'd3, 32'd7, 16'h7FFC);
      step(m[1:0], 2'd3, 32'd7, 16'h7FFC);   // possibly killed slot: R8
      step(m[1:0], 2'd0, 32'd0, 16'd0);
      step(m[1:0], 2'd3, 32'd0, 16'h8000);
      step(m[1:0], 2'd0, 32'd0, 16'd0);
      // R2: both conditions, both outcomes
      step(m[1:0], 2'd1, 32'd0, 16'h0040);
      step(m[1:0], 2'd0, 32'd0, 16'd0);
      step(m[1:0], 2'd1, 32'd5, 16'h0040);
      step(m[1:0], 2'd0, 32'd0, 16'd0);
      step(m[1:0], 2'd2, 32'd0, 16'hFFC0);
      step(m[1:0], 2'd0, 32'd0, 16'd0);
      step(m[1:0], 2'd2, 32'h8000_0000, 16'hFFC0);
      step(m[1:0], 2'd2, 32'd1, 16'h0010);
    end
    // constrained random: mode changes in runs, kinds biased toward none
    for (int blk = 0; blk < 80; blk++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      for (int i = 0; i < 50; i++) begin
        logic [1:0] k;
        logic [31:0] r;
        k = ($urandom_range(0, 9) < 4) ? 2'd0 : 2'($urandom_range(1, 3));
        r = ($urandom_range(0, 1) == 0) ? 32'd0 : $urandom;
        step(m, k, r, 16'($urandom));
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule